// File: doc/BRIEF.md
# Dual-Divider Conversion Pacer with Start Gate

This block produces the conversion strobe that a scan controller uses to start each analog conversion. In internal mode a master timebase (10 MHz, made from the system clock by a fixed prescaler) passes through two cascaded 16-bit programmable dividers. The strobe period is therefore the product of the two divisors times 100 ns. In external mode each rising edge on a pacer input pin yields one strobe. A 2-bit source code picks the mode or turns pacing off. Clearing it is the cancel path that control logic uses when a sample limit is reached or an overrun occurs.

An optional start gate holds internal pacing until a rising edge arrives on a trigger pin. The gate only applies when the dividers pace the conversions. When the conversions are clocked externally, the gate bit is ignored. Both pins pass through two-flop synchronizers before use. Every strobe is a single registered system-clock pulse.

Top module: `dual_pacer`

## Requirements
- R1: After reset the strobe is low, and with source code 0 no strobe appears whatever the divisors and pins do.
- R2: With source code 3 (internal) and the gate bit clear, the first strobe appears TB_DIV*N1*N2 clock cycles after the first clock edge that samples code 3, and later strobes follow at that same interval. N1 and N2 are the fast-stage and slow-stage divisors.
- R3: A divisor value of 0 counts as 65536.
- R4: A divisor written while pacing runs takes effect at that stage's next terminal count, and the count already in progress finishes with the old value.
- R5: With source code 2 (external), each rising edge of the pacer pin gives exactly one strobe, registered three clock edges after the edge reaches the pin. A pin held high gives only one strobe.
- R6: Source codes 0 and 1 disable pacing. Leaving codes 2 or 3 suppresses the strobe from the very next clock edge onward.
- R7: With code 3 and the gate bit set, no strobe appears until a rising edge on the trigger pin. The first strobe then appears TB_DIV*N1*N2 + 3 edges after the edge reaches the pin.
- R8: With code 2, the gate bit and the trigger pin have no effect. Strobes follow the pacer pin alone.
- R9: The strobe is never high for two consecutive cycles.
- R10: In internal mode, when each divisor product is at least 10, consecutive strobes are at least 10 master ticks apart (1 us).
- R11: After leaving internal mode and returning to it with the gate bit set, pacing waits for a new trigger edge. An earlier trigger edge does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Pacer source: 0 off, 1 reserved (off), 2 external pin, 3 internal dividers |
| start_gate_en | input | 1 | Hold internal pacing until a trigger edge |
| div_fast | input | 16 | First-stage divisor (0 means 65536) |
| div_slow | input | 16 | Second-stage divisor (0 means 65536) |
| ext_pace | input | 1 | Asynchronous external pacer pin |
| ext_trig | input | 1 | Asynchronous external start-trigger pin |
| conv_strobe | output | 1 | Single-cycle conversion strobe |

## Verification
The minimum-interval check assumes that every divisor pair applied in internal mode has a product of at least 10, including the mixed products that arise while a new value waits for a terminal count. All divisor sets in the stimulus satisfy this. The one-cycle-width check relies on the external pins staying low for at least one cycle between pulses, and the stimulus always returns each pin low before raising it again. The gate and external-mode checks assume the pins are driven away from clock edges, and the bench changes them only on falling edges.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_RSVD = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_INT  = 2'd3
  } pace_src_e;

  // fastest allowed conversion interval, in master ticks (1 us at 10 MHz)
  localparam int unsigned MIN_TICKS = 10;

endpackage

// File: rtl/pacer_sync.sv
module pacer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pacer_stage.sv
module pacer_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         tick_i,
  input  logic [W-1:0] div_i,
  output logic         term_o
);
  logic [W:0] eff;
  logic [W:0] cnt_q;

  assign eff    = (div_i == '0) ? {1'b1, {W{1'b0}}} : {1'b0, div_i};
  assign term_o = tick_i && (cnt_q == (W+1)'(1));

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt_q <= eff;
    else if (term_o)  cnt_q <= eff;
    else if (tick_i)  cnt_q <= cnt_q - (W+1)'(1);
  end
endmodule

// File: rtl/dual_pacer.sv
module dual_pacer #(
  parameter int DIV_W   = 16,
  parameter int TB_DIV  = 10,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel,
  input  logic             start_gate_en,
  input  logic [DIV_W-1:0] div_fast,
  input  logic [DIV_W-1:0] div_slow,
  input  logic             ext_pace,
  input  logic             ext_trig,
  output logic             conv_strobe
);
  import pacer_pkg::*;

  localparam int N_ST = 2;

  logic             pace_rise, trig_rise;
  logic             mode_int, mode_ext;
  logic             run_q, mtick, fire, strobe_q;
  logic [DIV_W-1:0] div_arr [N_ST];
  logic [N_ST:0]    tk;

  assign div_arr[0] = div_fast;
  assign div_arr[1] = div_slow;

  pacer_sync #(.STAGES(SYNC_FF)) u_pace_sync (
    .clk(clk), .rst(rst), .pin(ext_pace), .rise(pace_rise)
  );
  pacer_sync #(.STAGES(SYNC_FF)) u_trig_sync (
    .clk(clk), .rst(rst), .pin(ext_trig), .rise(trig_rise)
  );

  assign mode_int = (src_sel == SRC_INT);
  assign mode_ext = (src_sel == SRC_EXT);

  // run state for the divider chain; the start gate matters only here
  always_ff @(posedge clk) begin
    if (rst || !mode_int)                         run_q <= 1'b0;
    else if (!run_q && (!start_gate_en || trig_rise)) run_q <= 1'b1;
  end

  // master timebase prescaler
  generate
    if (TB_DIV > 1) begin : g_pre
      localparam int PW = $clog2(TB_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || !run_q)     pre_q <= PW'(TB_DIV - 1);
        else if (pre_q == '0)  pre_q <= PW'(TB_DIV - 1);
        else                   pre_q <= pre_q - PW'(1);
      end
      assign mtick = run_q && (pre_q == '0);
    end else begin : g_nopre
      assign mtick = run_q;
    end
  endgenerate

  assign tk[0] = mtick;

  generate
    for (genvar i = 0; i < N_ST; i++) begin : g_stage
      pacer_stage #(.W(DIV_W)) u_stage (
        .clk(clk), .rst(rst), .hold(!run_q),
        .tick_i(tk[i]), .div_i(div_arr[i]), .term_o(tk[i+1])
      );
    end
  endgenerate

  always_comb begin
    if (mode_ext)      fire = pace_rise;
    else if (mode_int) fire = tk[N_ST];
    else               fire = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= fire;
  end

  assign conv_strobe = strobe_q;
endmodule

// File: rtl/dual_pacer_chk.sv
module dual_pacer_chk #(
  parameter int TB_DIV = 10
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] src_sel,
  input logic       start_gate_en,
  input logic       conv_strobe,
  input logic       pace_rise,
  input logic       trig_rise
);
  import pacer_pkg::*;

  localparam int unsigned MIN_CYC = MIN_TICKS * TB_DIV;

  logic [31:0] gap_q;
  logic        have_prev_q;
  logic        free_q;

  always_ff @(posedge clk) begin
    if (rst || src_sel != SRC_INT) begin
      gap_q       <= '0;
      have_prev_q <= 1'b0;
    end else if (conv_strobe) begin
      gap_q       <= '0;
      have_prev_q <= 1'b1;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || src_sel != SRC_INT)         free_q <= 1'b0;
    else if (!start_gate_en || trig_rise)  free_q <= 1'b1;
  end

  // R6
  cancel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (src_sel != SRC_EXT && src_sel != SRC_INT) |=> !conv_strobe);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_strobe |=> !conv_strobe);

  // R10
  min_interval_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_strobe && have_prev_q && src_sel == SRC_INT) |-> (gap_q + 32'd1 >= MIN_CYC));

  // R7
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_strobe && $past(src_sel) == SRC_INT) |-> free_q);

  // R5
  ext_source_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_strobe && $past(src_sel) == SRC_EXT) |-> $past(pace_rise));
endmodule

bind dual_pacer dual_pacer_chk #(.TB_DIV(TB_DIV)) u_chk (
  .clk(clk), .rst(rst), .src_sel(src_sel), .start_gate_en(start_gate_en),
  .conv_strobe(conv_strobe), .pace_rise(pace_rise), .trig_rise(trig_rise)
);

// File: tb/dual_pacer_test.sv
`timescale 1ns/1ps
module dual_pacer_test;
  localparam int TB = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel = 2'd0;
  logic        start_gate_en = 1'b0;
  logic [15:0] div_fast = 16'd2;
  logic [15:0] div_slow = 16'd5;
  logic        ext_pace = 1'b0;
  logic        ext_trig = 1'b0;
  logic        conv_strobe;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  dual_pacer #(.DIV_W(16), .TB_DIV(TB), .SYNC_FF(2)) uut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .start_gate_en(start_gate_en),
    .div_fast(div_fast), .div_slow(div_slow), .ext_pace(ext_pace),
    .ext_trig(ext_trig), .conv_strobe(conv_strobe)
  );

  task automatic chk(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts edges until a strobe is seen; pins are released after the first edge
  task automatic wait_strobe(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (n == 1) begin ext_pace = 1'b0; ext_trig = 1'b0; end
      if (conv_strobe) break;
    end
  endtask

  task automatic count_strobes(input int cycles, output int c);
    c = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 0) begin ext_pace = 1'b0; ext_trig = 1'b0; end
      if (conv_strobe) c++;
    end
  endtask

  task automatic go_idle(input int cycles);
    int c;
    src_sel = 2'd0;
    count_strobes(cycles, c);
  endtask

  task automatic t_reset();
    int c;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(conv_strobe, 0, "R1 strobe during reset");
    rst = 1'b0;
    ext_pace = 1'b1;
    count_strobes(60, c);
    chk(c, 0, "R1 no strobe with source off");
  endtask

  task automatic t_internal();
    int n;
    div_fast = 16'd2; div_slow = 16'd5; start_gate_en = 1'b0;
    src_sel = 2'd3;
    wait_strobe(200, n);
    chk(n, 2*5*TB + 1, "R2 first strobe latency");
    @(posedge clk); @(negedge clk);
    chk(conv_strobe, 0, "R9 strobe one cycle");
    wait_strobe(200, n);
    chk(n, 2*5*TB - 1, "R2 interval after width check");
    wait_strobe(200, n);
    chk(n, 2*5*TB, "R2 steady interval");
    wait_strobe(200, n);
    chk(n, 2*5*TB, "R10 interval at fastest rate");
  endtask

  task automatic t_reload();
    int n;
    div_fast = 16'd4;
    wait_strobe(400, n);
    chk(n, (2 + 4*4)*TB, "R4 fast stage keeps old count");
    wait_strobe(400, n);
    chk(n, 4*5*TB, "R4 fast stage new value");
    div_slow = 16'd3;
    wait_strobe(400, n);
    chk(n, 4*5*TB, "R4 slow stage keeps old count");
    wait_strobe(400, n);
    chk(n, 4*3*TB, "R4 slow stage new value");
  endtask

  task automatic t_cancel();
    int c;
    for (int i = 0; i < 4*3*TB - 1; i++) @(negedge clk);
    src_sel = 2'd0;
    count_strobes(100, c);
    chk(c, 0, "R6 cancel suppresses pending strobe");
    src_sel = 2'd1;
    ext_pace = 1'b1;
    count_strobes(100, c);
    chk(c, 0, "R6 reserved code is off");
  endtask

  task automatic t_ext();
    int n, c;
    src_sel = 2'd2;
    repeat (4) @(negedge clk);
    ext_pace = 1'b1;
    wait_strobe(20, n);
    chk(n, 3, "R5 external strobe latency");
    count_strobes(10, c);
    chk(c, 0, "R9 single strobe per edge");
    ext_pace = 1'b1;
    c = 0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (conv_strobe) c++;
    end
    ext_pace = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (conv_strobe) c++;
    end
    chk(c, 1, "R5 held pin gives one strobe");
  endtask

  task automatic t_ext_gate();
    int n, c;
    start_gate_en = 1'b1;
    src_sel = 2'd2;
    ext_trig = 1'b1;
    count_strobes(20, c);
    chk(c, 0, "R8 trigger alone gives nothing");
    ext_pace = 1'b1;
    wait_strobe(20, n);
    chk(n, 3, "R8 gate ignored in external mode");
  endtask

  task automatic t_gate();
    int n, c;
    go_idle(5);
    div_fast = 16'd2; div_slow = 16'd5; start_gate_en = 1'b1;
    src_sel = 2'd3;
    count_strobes(60, c);
    chk(c, 0, "R7 held until trigger");
    ext_trig = 1'b1;
    wait_strobe(200, n);
    chk(n, 2*5*TB + 3, "R7 first strobe after trigger");
  endtask

  task automatic t_rearm();
    int n, c;
    go_idle(5);
    src_sel = 2'd3;
    count_strobes(60, c);
    chk(c, 0, "R11 old trigger does not count");
    ext_trig = 1'b1;
    wait_strobe(200, n);
    chk(n, 2*5*TB + 3, "R11 new trigger starts pacing");
  endtask

  task automatic t_zero();
    int n;
    go_idle(5);
    start_gate_en = 1'b0;
    div_fast = 16'd0; div_slow = 16'd1;
    src_sel = 2'd3;
    wait_strobe(140000, n);
    chk(n, 65536*TB + 1, "R3 zero divisor is 65536");
  endtask

  initial begin
    #1_900_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_internal();
    t_reload();
    t_cancel();
    t_ext();
    t_ext_gate();
    t_gate();
    t_rearm();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule